// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller keeps a running sum of the coins a customer drops in and releases one item as soon as that sum covers the asking price. A coin detector raises a strobe for each coin and presents the coin's worth on an unsigned bus. The price arrives on a separate unsigned bus and may change at any time.

The block is split into a control state machine and a datapath. The control machine has four states: a clearing state, an idle waiting state, an accumulate state and a release state. The datapath holds the sum register, an adder and an unsigned magnitude comparator. The control machine drives the datapath through two strobes. The sum register is clocked, so every clear or load asked for in a state lands on the rising edge that leaves that state.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous active-high `rst` forces the clearing state. `dispense` is 0 while `rst` is high and in the first cycle after it is released. That first cycle is the waiting state, with the sum at 0.
- R2: A `coinSeen` pulse sampled in the waiting state moves the machine to the accumulate state for one cycle. At the edge that leaves the accumulate state, the value on `coinValue` during that cycle is added to the sum. The value present in the detect cycle is not used. The machine then returns to the waiting state.
- R3: When the machine is in the waiting state with `coinSeen` low and sum >= `priceIn`, `dispense` is 1 for exactly one cycle, starting at the next rising edge.
- R4: While sum < `priceIn`, `dispense` stays 0.
- R5: A `coinSeen` high in the waiting state takes priority over release, even when sum >= `priceIn`.
- R6: After the release cycle, the machine spends one cycle in the clearing state and then returns to the waiting state with the sum at 0. A purchase therefore never carries credit into the next one.
- R7: The adder and the comparator treat all buses as unsigned. A price of 128 is not covered by a sum of 127.
- R8: The sum wraps modulo 2^WIDTH with no flag. With WIDTH=8, 200 + 100 gives 44.
- R9: `priceIn` is compared on every waiting cycle. Lowering it to the current sum causes a release on the next edge.
- R10: When `priceIn` is 0 and no coins arrive, `dispense` pulses once every three cycles, following the clearing, waiting and release states in turn.
- R11: If `coinSeen` is held high, the coin is added once per pass through the accumulate state, which is once every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coinSeen | input | 1 | One-cycle strobe, one per inserted coin |
| coinValue | input | WIDTH | Unsigned worth of the coin, sampled in the accumulate cycle |
| priceIn | input | WIDTH | Unsigned item price |
| dispense | output | 1 | Release strobe, decoded from the state register |

## Verification
A coin strobe sampled at edge N causes the addition at edge N+1. A waiting cycle that meets the price raises `dispense` after the following edge, and `dispense` falls one edge later. The sum is zero again two edges after the release cycle. The bench drives inputs and samples `dispense` only on falling edges. Each task advances exactly one falling edge per expected register stage, so every comparison lands in the cycle the requirement names. Cases where a wrong sum would show up only later, such as wrap, carried-over credit and a stale coin value, are exposed by a deliberately sized follow-up coin whose release timing is predicted.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_INIT     = 2'd0,
    ST_WAIT     = 2'd1,
    ST_ADD      = 2'd2,
    ST_DISPENSE = 2'd3
  } vend_state_e;

  // strobes from the control machine to the datapath
  typedef struct packed {
    logic clearTotal;
    logic loadSum;
  } vend_strobe_t;

endpackage

// File: rtl/vend_accum_reg.sv
module vend_accum_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clearEn,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] regQ
);

  always_ff @(posedge clk) begin
    if (rst || clearEn) begin
      regQ <= '0;
    end else if (loadEn) begin
      regQ <= loadData;
    end
  end

endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  vend_strobe_t     strobe,
  input  logic [WIDTH-1:0] coinValue,
  input  logic [WIDTH-1:0] priceIn,
  output logic [WIDTH-1:0] totalVal,
  output logic             reached
);

  logic [WIDTH-1:0] sumNext;

  // modulo 2^WIDTH adder, carry dropped on purpose
  assign sumNext = totalVal + coinValue;

  // unsigned magnitude comparison
  assign reached = (totalVal >= priceIn);

  vend_accum_reg #(.WIDTH(WIDTH)) totalReg (
    .clk      (clk),
    .rst      (rst),
    .clearEn  (strobe.clearTotal),
    .loadEn   (strobe.loadSum),
    .loadData (sumNext),
    .regQ     (totalVal)
  );

endmodule

// File: rtl/vend_ctrl_fsm.sv
module vend_ctrl_fsm
  import vend_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         coinSeen,
  input  logic         reached,
  output vend_strobe_t strobe,
  output vend_state_e  stateQ,
  output logic         dispense
);

  vend_state_e stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_INIT:     stateD = ST_WAIT;
      ST_WAIT: begin
        if (coinSeen)     stateD = ST_ADD;
        else if (reached) stateD = ST_DISPENSE;
        else              stateD = ST_WAIT;
      end
      ST_ADD:      stateD = ST_WAIT;
      ST_DISPENSE: stateD = ST_INIT;
      default:     stateD = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_INIT;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobe.clearTotal = (stateQ == ST_INIT);
    strobe.loadSum    = (stateQ == ST_ADD);
  end

  assign dispense = (stateQ == ST_DISPENSE);

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coinSeen,
  input  logic [WIDTH-1:0] coinValue,
  input  logic [WIDTH-1:0] priceIn,
  output logic             dispense
);

  vend_strobe_t     strobe;
  vend_state_e      stateQ;
  logic             reached;
  logic [WIDTH-1:0] totalVal;
  logic             inWait;
  logic             inAdd;

  vend_ctrl_fsm ctrl (
    .clk      (clk),
    .rst      (rst),
    .coinSeen (coinSeen),
    .reached  (reached),
    .strobe   (strobe),
    .stateQ   (stateQ),
    .dispense (dispense)
  );

  vend_datapath #(.WIDTH(WIDTH)) dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .coinValue (coinValue),
    .priceIn   (priceIn),
    .totalVal  (totalVal),
    .reached   (reached)
  );

  // state views for the bound checker
  assign inWait = (stateQ == ST_WAIT);
  assign inAdd  = (stateQ == ST_ADD);

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             coinSeen,
  input logic [WIDTH-1:0] coinValue,
  input logic [WIDTH-1:0] priceIn,
  input logic             dispense,
  input logic [WIDTH-1:0] totalVal,
  input logic             inWait,
  input logic             inAdd
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !dispense);

  // R2
  add_once_chk: assert property (@(posedge clk) disable iff (rst)
    inAdd |=> (totalVal == WIDTH'($past(totalVal) + $past(coinValue))));

  // R3
  release_due_chk: assert property (@(posedge clk) disable iff (rst)
    (inWait && !coinSeen && (totalVal >= priceIn)) |=> dispense);

  // R3
  release_single_chk: assert property (@(posedge clk) disable iff (rst)
    dispense |=> !dispense);

  // R4
  short_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (inWait && (totalVal < priceIn)) |=> !dispense);

  // R5
  coin_first_chk: assert property (@(posedge clk) disable iff (rst)
    (inWait && coinSeen) |=> inAdd);

  // R6
  credit_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    dispense |=> ##1 (inWait && (totalVal == '0)));

endmodule

bind coin_vend_ctrl coin_vend_chk #(.WIDTH(WIDTH)) chkI (
  .clk       (clk),
  .rst       (rst),
  .coinSeen  (coinSeen),
  .coinValue (coinValue),
  .priceIn   (priceIn),
  .dispense  (dispense),
  .totalVal  (totalVal),
  .inWait    (inWait),
  .inAdd     (inAdd)
);

// File: tb/coin_vend_ctrl_test.sv
module coin_vend_ctrl_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         coinSeen = 1'b0;
  logic [W-1:0] coinValue = '0;
  logic [W-1:0] priceIn = '0;
  logic         dispense;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  coin_vend_ctrl #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .coinSeen  (coinSeen),
    .coinValue (coinValue),
    .priceIn   (priceIn),
    .dispense  (dispense)
  );

  task automatic checkBit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dispense actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // returns at the falling edge of the first waiting cycle
  task automatic doReset();
    tick();
    rst = 1'b1;
    coinSeen = 1'b0;
    repeat (3) begin
      tick();
      checkBit("R1 in reset", dispense, 1'b0);
    end
    rst = 1'b0;
    tick();
    checkBit("R1 after release", dispense, 1'b0);
  endtask

  // called in a waiting cycle, returns in the next waiting cycle
  task automatic insertCoin(input logic [W-1:0] v);
    coinSeen = 1'b1;
    coinValue = v;
    tick();
    coinSeen = 1'b0;
    tick();
  endtask

  task automatic expectDispense(input string req);
    checkBit(req, dispense, 1'b0);
    tick();
    checkBit(req, dispense, 1'b1);
    tick();
    checkBit(req, dispense, 1'b0);
    tick();
  endtask

  task automatic expectQuiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      checkBit(req, dispense, 1'b0);
      tick();
    end
  endtask

  task automatic testReset();
    priceIn = 8'd5;
    doReset();
    expectQuiet("R1 idle", 4);
  endtask

  task automatic testExact();
    priceIn = 8'd25;
    doReset();
    insertCoin(8'd25);
    expectDispense("R3 equal price");
  endtask

  task automatic testAccumAndClear();
    priceIn = 8'd50;
    doReset();
    insertCoin(8'd30);
    expectQuiet("R4 short", 3);
    insertCoin(8'd30);
    expectDispense("R2 two coins");
    expectQuiet("R6 credit cleared", 5);
    insertCoin(8'd20);
    expectQuiet("R6 fresh sum", 3);
  endtask

  task automatic testSampleCycle();
    priceIn = 8'd50;
    doReset();
    coinSeen = 1'b1;
    coinValue = 8'd99;
    tick();
    coinSeen = 1'b0;
    coinValue = 8'd20;
    tick();
    expectQuiet("R2 add-cycle value", 3);
    insertCoin(8'd30);
    expectDispense("R2 sum 50");
  endtask

  task automatic testPriority();
    priceIn = 8'd10;
    doReset();
    coinSeen = 1'b1;
    coinValue = 8'd10;
    for (int i = 0; i < 6; i++) begin
      tick();
      checkBit("R5 coin first", dispense, 1'b0);
    end
    coinSeen = 1'b0;
    expectDispense("R5 after release of coin");
  endtask

  task automatic testHeldCoin();
    priceIn = 8'd40;
    doReset();
    coinSeen = 1'b1;
    coinValue = 8'd10;
    repeat (6) tick();
    coinSeen = 1'b0;
    expectQuiet("R11 three adds", 3);
    insertCoin(8'd10);
    expectDispense("R11 fourth add");
  endtask

  task automatic testUnsigned();
    priceIn = 8'd128;
    doReset();
    insertCoin(8'd127);
    expectQuiet("R7 unsigned", 3);
    insertCoin(8'd1);
    expectDispense("R7 reach 128");
  endtask

  task automatic testWrap();
    priceIn = 8'd255;
    doReset();
    insertCoin(8'd200);
    insertCoin(8'd100);
    expectQuiet("R8 wrap to 44", 3);
    insertCoin(8'd211);
    expectDispense("R8 44+211");
  endtask

  task automatic testPriceChange();
    priceIn = 8'd50;
    doReset();
    insertCoin(8'd30);
    expectQuiet("R9 before change", 2);
    priceIn = 8'd30;
    expectDispense("R9 lowered price");
  endtask

  task automatic testZeroPrice();
    priceIn = 8'd0;
    doReset();
    expectDispense("R10 first");
    expectDispense("R10 second");
    priceIn = 8'd100;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testExact();
    testAccumAndClear();
    testSampleCycle();
    testPriority();
    testHeldCoin();
    testUnsigned();
    testWrap();
    testPriceChange();
    testZeroPrice();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule